// File: doc/BRIEF.md
# Execution-Order Trace Cache

This block holds short runs of instructions in the order they actually executed, not in the order they sit in memory. A run may cross taken branches, so one line can deliver several basic blocks to the fetch stage in a single lookup. A lookup presents the fetch PC and a vector of branch predictions. The line hits only when its start address matches and the predictions agree with the branch directions fixed inside the line. On a hit the block returns the whole run, its length and the address to fetch after it.

When a lookup misses, the block remembers the missing PC. It then watches the stream of retired instructions. Collection starts when the retired instruction at that PC appears. Each retired instruction is appended with its branch flag, resolved direction and target. The line closes when it holds the maximum instruction count or the maximum branch count, and it is written into a direct-mapped array one cycle later. Each line stores its own next addresses: the address after the last instruction, and the target of the last branch.

Top module: `trace_cache`

## Requirements
- R1: After reset every line is invalid, and every lookup misses.
- R2: While hit_o is low, len_o, next_pc_o and instr_o are all zero.
- R3: A line is selected by PC bits [3:2] (the set index) and matched on PC bits [31:4]. Interior branches are the line's branches, minus the last one when the line ends on a branch. A hit requires a valid line, an equal tag, and pred_i[k] equal to the stored direction of the k-th interior branch, counting from 0, for every interior branch.
- R4: On a hit, len_o gives the instruction count, from 1 to 24. Slot k of instr_o, at bits [32k+31:32k], holds the k-th collected instruction, and slots at or beyond len_o read zero.
- R5: On a hit, next_pc_o is the last branch's target when the line's last instruction is a branch and pred_i[b-1] is 1, where b is the line's branch count. Otherwise it is the last instruction's PC plus 4.
- R6: A lookup that misses while the fill unit is idle or waiting records fetch_pc_i as the start PC; a later miss replaces it. While waiting, retired instructions whose PC differs from the start PC are ignored. Collection begins with the first one whose PC equals it.
- R7: Collection stops on the instruction that brings the count to 24 or the branch count to 3, whichever comes first. That instruction is the last one in the line.
- R8: The line is written on the clock edge that follows the cycle after the closing instruction, and lookups see it from then on. Retired instructions offered during that write cycle are ignored.
- R9: A lookup to the set being written in the current cycle misses.
- R10: The cache is direct-mapped: a new line overwrites its set, and the old start PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Lookup request this cycle |
| fetch_pc_i | input | 32 | Fetch PC to look up |
| pred_i | input | 3 | Branch predictions, bit k for the k-th branch of the line |
| hit_o | output | 1 | Lookup hit |
| len_o | output | 5 | Instruction count of the hit line |
| instr_o | output | 768 | Instructions of the hit line, slot 0 in the low bits |
| next_pc_o | output | 32 | Address to fetch after the line |
| fill_valid_i | input | 1 | Retired instruction offered |
| fill_pc_i | input | 32 | PC of the retired instruction |
| fill_instr_i | input | 32 | Retired instruction word |
| fill_br_i | input | 1 | Retired instruction is a branch |
| fill_taken_i | input | 1 | Resolved branch direction, 1 = taken |
| fill_tgt_i | input | 32 | Branch target address |

## Verification
Lines are built from retired streams of four shapes, each of which ends the line in a different way:
- Streams with no branches close at the 24-instruction limit and return the fall-through address.
- Streams made only of branches close after three instructions on the terminal branch.
- Streams with a single branch placed in the last slot end on a branch that was closed by the count limit.
- Random streams mix both limits.

Each line is then looked up in several ways. One lookup uses predictions equal to the stored flags, with the terminal prediction set both ways, which separates the target from the fall-through. Another flips one interior prediction, which separates the direction check from the tag check. A third uses a foreign tag in the same set. A fourth uses an older PC whose line has been replaced. Decoy retired instructions are offered before collection starts and again in the write cycle, and a lookup in the write cycle probes the same-set miss rule.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE    = 2'd0,
    FILL_ARMED   = 2'd1,
    FILL_COLLECT = 2'd2,
    FILL_WRITE   = 2'd3
  } fill_state_e;
endpackage

// File: rtl/tc_fill.sv
module tc_fill import tc_pkg::*; #(
  parameter int PC_W        = 32,
  parameter int INSTR_W     = 32,
  parameter int TRACE_LEN   = 24,
  parameter int MAX_BR      = 3,
  parameter int SETS        = 4,
  parameter int INSTR_BYTES = 4,
  localparam int LEN_W  = $clog2(TRACE_LEN + 1),
  localparam int BCNT_W = $clog2(MAX_BR + 1),
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(INSTR_BYTES),
  localparam int TAG_W  = PC_W - IDX_W - OFF_W,
  localparam int FLAG_W = MAX_BR - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         miss_i,
  input  logic [PC_W-1:0]              miss_pc_i,
  input  logic                         fill_valid_i,
  input  logic [PC_W-1:0]              fill_pc_i,
  input  logic [INSTR_W-1:0]           fill_instr_i,
  input  logic                         fill_br_i,
  input  logic                         fill_taken_i,
  input  logic [PC_W-1:0]              fill_tgt_i,
  output logic                         wr_en_o,
  output logic [IDX_W-1:0]             wr_idx_o,
  output logic [TAG_W-1:0]             wr_tag_o,
  output logic [LEN_W-1:0]             wr_len_o,
  output logic [BCNT_W-1:0]            wr_brcnt_o,
  output logic                         wr_endbr_o,
  output logic [FLAG_W-1:0]            wr_flags_o,
  output logic [PC_W-1:0]              wr_fall_o,
  output logic [PC_W-1:0]              wr_tgt_o,
  output logic [TRACE_LEN*INSTR_W-1:0] wr_instr_o
);

  fill_state_e          state_q;
  logic [PC_W-1:0]      start_pc_q, last_pc_q, tgt_q;
  logic [LEN_W-1:0]     len_q;
  logic [BCNT_W-1:0]    br_q;
  logic                 endbr_q;
  logic [FLAG_W-1:0]    flags_q;
  logic [INSTR_W-1:0]   slot_q [TRACE_LEN];

  logic                 accept, close;
  logic [LEN_W-1:0]     base_len, next_len;
  logic [BCNT_W-1:0]    base_br, next_br;

  always_comb begin
    accept   = fill_valid_i &&
               (((state_q == FILL_ARMED) && (fill_pc_i == start_pc_q)) ||
                (state_q == FILL_COLLECT));
    base_len = (state_q == FILL_COLLECT) ? len_q : '0;
    base_br  = (state_q == FILL_COLLECT) ? br_q  : '0;
    next_len = base_len + LEN_W'(1);
    next_br  = base_br + BCNT_W'(fill_br_i);
    close    = (next_len == LEN_W'(TRACE_LEN)) || (next_br == BCNT_W'(MAX_BR));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FILL_IDLE;
      start_pc_q <= '0;
    end else begin
      unique case (state_q)
        FILL_IDLE: if (miss_i) begin
          start_pc_q <= miss_pc_i;
          state_q    <= FILL_ARMED;
        end
        FILL_ARMED: begin
          if (accept)      state_q    <= close ? FILL_WRITE : FILL_COLLECT;
          else if (miss_i) start_pc_q <= miss_pc_i;  // newest miss wins
        end
        FILL_COLLECT: if (accept && close) state_q <= FILL_WRITE;
        FILL_WRITE:   state_q <= FILL_IDLE;
        default:      state_q <= FILL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q     <= '0;
      br_q      <= '0;
      endbr_q   <= 1'b0;
      flags_q   <= '0;
      last_pc_q <= '0;
      tgt_q     <= '0;
      for (int i = 0; i < TRACE_LEN; i++) slot_q[i] <= '0;
    end else if (accept) begin
      len_q     <= next_len;
      br_q      <= next_br;
      endbr_q   <= fill_br_i;
      last_pc_q <= fill_pc_i;
      if (fill_br_i) tgt_q <= fill_tgt_i;
      if (state_q == FILL_ARMED) begin
        flags_q <= '0;
        for (int i = 0; i < TRACE_LEN; i++) slot_q[i] <= '0;
      end
      for (int k = 0; k < FLAG_W; k++)
        if (fill_br_i && (base_br == BCNT_W'(k))) flags_q[k] <= fill_taken_i;
      slot_q[base_len] <= fill_instr_i;
    end
  end

  assign wr_en_o    = (state_q == FILL_WRITE);
  assign wr_idx_o   = start_pc_q[OFF_W +: IDX_W];
  assign wr_tag_o   = start_pc_q[PC_W-1 -: TAG_W];
  assign wr_len_o   = len_q;
  assign wr_brcnt_o = br_q;
  assign wr_endbr_o = endbr_q;
  assign wr_flags_o = flags_q;
  assign wr_fall_o  = last_pc_q + PC_W'(INSTR_BYTES);
  assign wr_tgt_o   = tgt_q;

  for (genvar g = 0; g < TRACE_LEN; g++) begin : g_flat
    assign wr_instr_o[g*INSTR_W +: INSTR_W] = slot_q[g];
  end

endmodule

// File: rtl/tc_store.sv
module tc_store #(
  parameter int PC_W      = 32,
  parameter int INSTR_W   = 32,
  parameter int TRACE_LEN = 24,
  parameter int MAX_BR    = 3,
  parameter int SETS      = 4,
  parameter int TAG_W     = 28,
  localparam int LEN_W  = $clog2(TRACE_LEN + 1),
  localparam int BCNT_W = $clog2(MAX_BR + 1),
  localparam int IDX_W  = $clog2(SETS),
  localparam int FLAG_W = MAX_BR - 1,
  localparam int LINE_W = TRACE_LEN * INSTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [BCNT_W-1:0] wr_brcnt_i,
  input  logic              wr_endbr_i,
  input  logic [FLAG_W-1:0] wr_flags_i,
  input  logic [PC_W-1:0]   wr_fall_i,
  input  logic [PC_W-1:0]   wr_tgt_i,
  input  logic [LINE_W-1:0] wr_instr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [BCNT_W-1:0] rd_brcnt_o,
  output logic              rd_endbr_o,
  output logic [FLAG_W-1:0] rd_flags_o,
  output logic [PC_W-1:0]   rd_fall_o,
  output logic [PC_W-1:0]   rd_tgt_o,
  output logic [LINE_W-1:0] rd_instr_o
);

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q   [SETS];
  logic [LEN_W-1:0]  len_q   [SETS];
  logic [BCNT_W-1:0] brcnt_q [SETS];
  logic              endbr_q [SETS];
  logic [FLAG_W-1:0] flags_q [SETS];
  logic [PC_W-1:0]   fall_q  [SETS];
  logic [PC_W-1:0]   tgt_q   [SETS];
  logic [LINE_W-1:0] instr_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  valid_q[s] <= 1'b0;
      else if (sel) valid_q[s] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[s]   <= wr_tag_i;
        len_q[s]   <= wr_len_i;
        brcnt_q[s] <= wr_brcnt_i;
        endbr_q[s] <= wr_endbr_i;
        flags_q[s] <= wr_flags_i;
        fall_q[s]  <= wr_fall_i;
        tgt_q[s]   <= wr_tgt_i;
        instr_q[s] <= wr_instr_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_len_o   = len_q[rd_idx_i];
  assign rd_brcnt_o = brcnt_q[rd_idx_i];
  assign rd_endbr_o = endbr_q[rd_idx_i];
  assign rd_flags_o = flags_q[rd_idx_i];
  assign rd_fall_o  = fall_q[rd_idx_i];
  assign rd_tgt_o   = tgt_q[rd_idx_i];
  assign rd_instr_o = instr_q[rd_idx_i];

endmodule

// File: rtl/tc_hit.sv
module tc_hit #(
  parameter int PC_W      = 32,
  parameter int INSTR_W   = 32,
  parameter int TRACE_LEN = 24,
  parameter int MAX_BR    = 3,
  parameter int TAG_W     = 28,
  localparam int LEN_W  = $clog2(TRACE_LEN + 1),
  localparam int BCNT_W = $clog2(MAX_BR + 1),
  localparam int FLAG_W = MAX_BR - 1,
  localparam int LINE_W = TRACE_LEN * INSTR_W
) (
  input  logic              rd_valid_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  input  logic [BCNT_W-1:0] rd_brcnt_i,
  input  logic              rd_endbr_i,
  input  logic [FLAG_W-1:0] rd_flags_i,
  input  logic [PC_W-1:0]   rd_fall_i,
  input  logic [PC_W-1:0]   rd_tgt_i,
  input  logic [LINE_W-1:0] rd_instr_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [MAX_BR-1:0] pred_i,
  input  logic              collide_i,
  output logic              hit_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [LINE_W-1:0] instr_o,
  output logic [PC_W-1:0]   next_pc_o
);

  logic [BCNT_W-1:0] n_inner, last_br;
  logic [FLAG_W-1:0] flag_ok;
  logic              pred_last;

  assign n_inner = rd_brcnt_i - BCNT_W'(rd_endbr_i);
  assign last_br = rd_brcnt_i - BCNT_W'(1);

  for (genvar k = 0; k < FLAG_W; k++) begin : g_flag
    assign flag_ok[k] = (BCNT_W'(k) >= n_inner) || (pred_i[k] == rd_flags_i[k]);
  end

  always_comb begin
    pred_last = 1'b0;
    for (int k = 0; k < MAX_BR; k++)
      if (last_br == BCNT_W'(k)) pred_last = pred_i[k];
  end

  assign hit_o     = rd_valid_i && (rd_tag_i == tag_i) && (&flag_ok) && !collide_i;
  assign len_o     = hit_o ? rd_len_i   : '0;
  assign instr_o   = hit_o ? rd_instr_i : '0;
  assign next_pc_o = !hit_o ? '0 : ((rd_endbr_i && pred_last) ? rd_tgt_i : rd_fall_i);

endmodule

// File: rtl/trace_cache.sv
module trace_cache #(
  parameter int PC_W        = 32,
  parameter int INSTR_W     = 32,
  parameter int TRACE_LEN   = 24,
  parameter int MAX_BR      = 3,
  parameter int SETS        = 4,
  parameter int INSTR_BYTES = 4,
  localparam int LEN_W  = $clog2(TRACE_LEN + 1),
  localparam int BCNT_W = $clog2(MAX_BR + 1),
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(INSTR_BYTES),
  localparam int TAG_W  = PC_W - IDX_W - OFF_W,
  localparam int FLAG_W = MAX_BR - 1,
  localparam int LINE_W = TRACE_LEN * INSTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic [MAX_BR-1:0] pred_i,
  output logic              hit_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [LINE_W-1:0] instr_o,
  output logic [PC_W-1:0]   next_pc_o,
  input  logic              fill_valid_i,
  input  logic [PC_W-1:0]   fill_pc_i,
  input  logic [INSTR_W-1:0] fill_instr_i,
  input  logic              fill_br_i,
  input  logic              fill_taken_i,
  input  logic [PC_W-1:0]   fill_tgt_i
);

  logic              fill_wr_en;
  logic [IDX_W-1:0]  fill_wr_idx;
  logic [TAG_W-1:0]  fill_wr_tag;
  logic [LEN_W-1:0]  fill_wr_len;
  logic [BCNT_W-1:0] fill_wr_brcnt;
  logic              fill_wr_endbr;
  logic [FLAG_W-1:0] fill_wr_flags;
  logic [PC_W-1:0]   fill_wr_fall, fill_wr_tgt;
  logic [LINE_W-1:0] fill_wr_instr;

  logic              rd_valid, rd_endbr;
  logic [TAG_W-1:0]  rd_tag;
  logic [LEN_W-1:0]  rd_len;
  logic [BCNT_W-1:0] rd_brcnt;
  logic [FLAG_W-1:0] rd_flags;
  logic [PC_W-1:0]   rd_fall, rd_tgt;
  logic [LINE_W-1:0] rd_instr;

  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;
  logic              collide, miss;

  assign look_idx = fetch_pc_i[OFF_W +: IDX_W];
  assign look_tag = fetch_pc_i[PC_W-1 -: TAG_W];
  assign collide  = fill_wr_en && (fill_wr_idx == look_idx);
  assign miss     = lookup_i && !hit_o;

  tc_fill #(
    .PC_W(PC_W), .INSTR_W(INSTR_W), .TRACE_LEN(TRACE_LEN),
    .MAX_BR(MAX_BR), .SETS(SETS), .INSTR_BYTES(INSTR_BYTES)
  ) i_fill (
    .clk_i, .rst_ni,
    .miss_i(miss), .miss_pc_i(fetch_pc_i),
    .fill_valid_i, .fill_pc_i, .fill_instr_i, .fill_br_i, .fill_taken_i, .fill_tgt_i,
    .wr_en_o(fill_wr_en), .wr_idx_o(fill_wr_idx), .wr_tag_o(fill_wr_tag),
    .wr_len_o(fill_wr_len), .wr_brcnt_o(fill_wr_brcnt), .wr_endbr_o(fill_wr_endbr),
    .wr_flags_o(fill_wr_flags), .wr_fall_o(fill_wr_fall), .wr_tgt_o(fill_wr_tgt),
    .wr_instr_o(fill_wr_instr)
  );

  tc_store #(
    .PC_W(PC_W), .INSTR_W(INSTR_W), .TRACE_LEN(TRACE_LEN),
    .MAX_BR(MAX_BR), .SETS(SETS), .TAG_W(TAG_W)
  ) i_store (
    .clk_i, .rst_ni,
    .wr_en_i(fill_wr_en), .wr_idx_i(fill_wr_idx), .wr_tag_i(fill_wr_tag),
    .wr_len_i(fill_wr_len), .wr_brcnt_i(fill_wr_brcnt), .wr_endbr_i(fill_wr_endbr),
    .wr_flags_i(fill_wr_flags), .wr_fall_i(fill_wr_fall), .wr_tgt_i(fill_wr_tgt),
    .wr_instr_i(fill_wr_instr),
    .rd_idx_i(look_idx),
    .rd_valid_o(rd_valid), .rd_tag_o(rd_tag), .rd_len_o(rd_len),
    .rd_brcnt_o(rd_brcnt), .rd_endbr_o(rd_endbr), .rd_flags_o(rd_flags),
    .rd_fall_o(rd_fall), .rd_tgt_o(rd_tgt), .rd_instr_o(rd_instr)
  );

  tc_hit #(
    .PC_W(PC_W), .INSTR_W(INSTR_W), .TRACE_LEN(TRACE_LEN),
    .MAX_BR(MAX_BR), .TAG_W(TAG_W)
  ) i_hit (
    .rd_valid_i(rd_valid), .rd_tag_i(rd_tag), .rd_len_i(rd_len),
    .rd_brcnt_i(rd_brcnt), .rd_endbr_i(rd_endbr), .rd_flags_i(rd_flags),
    .rd_fall_i(rd_fall), .rd_tgt_i(rd_tgt), .rd_instr_i(rd_instr),
    .tag_i(look_tag), .pred_i, .collide_i(collide),
    .hit_o, .len_o, .instr_o, .next_pc_o
  );

endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int PC_W      = 32,
  parameter int INSTR_W   = 32,
  parameter int TRACE_LEN = 24,
  parameter int MAX_BR    = 3,
  parameter int SETS      = 4,
  parameter int OFF_W     = 2,
  localparam int LEN_W  = $clog2(TRACE_LEN + 1),
  localparam int BCNT_W = $clog2(MAX_BR + 1),
  localparam int IDX_W  = $clog2(SETS)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         lookup_i,
  input logic [PC_W-1:0]              fetch_pc_i,
  input logic                         hit_o,
  input logic [LEN_W-1:0]             len_o,
  input logic [TRACE_LEN*INSTR_W-1:0] instr_o,
  input logic [PC_W-1:0]              next_pc_o,
  input logic                         wr_en_i,
  input logic [IDX_W-1:0]             wr_idx_i,
  input logic [LEN_W-1:0]             wr_len_i,
  input logic [BCNT_W-1:0]            wr_brcnt_i
);

  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (len_o == '0) && (next_pc_o == '0) && (instr_o == '0)); // R2

  AST_HIT_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (len_o != '0) && (len_o <= LEN_W'(TRACE_LEN))); // R4

  AST_CLOSE_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ((wr_len_i == LEN_W'(TRACE_LEN)) || (wr_brcnt_i == BCNT_W'(MAX_BR)))
                && (wr_brcnt_i <= BCNT_W'(MAX_BR))); // R7

  AST_WRITE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i); // R8

  AST_WRITE_SET_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && lookup_i && (fetch_pc_i[OFF_W +: IDX_W] == wr_idx_i)) |-> !hit_o); // R9

endmodule

bind trace_cache tc_checker #(
  .PC_W(PC_W), .INSTR_W(INSTR_W), .TRACE_LEN(TRACE_LEN),
  .MAX_BR(MAX_BR), .SETS(SETS), .OFF_W(OFF_W)
) i_tc_checker (
  .clk_i, .rst_ni, .lookup_i, .fetch_pc_i, .hit_o, .len_o, .instr_o, .next_pc_o,
  .wr_en_i(fill_wr_en), .wr_idx_i(fill_wr_idx),
  .wr_len_i(fill_wr_len), .wr_brcnt_i(fill_wr_brcnt)
);

// File: tb/test_trace_cache.sv
module test_trace_cache;
  localparam int N = 24;
  localparam int M = 3;
  localparam int S = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lookup_i = 1'b0;
  logic [31:0]   fetch_pc_i = '0;
  logic [M-1:0]  pred_i = '0;
  logic          hit_o;
  logic [4:0]    len_o;
  logic [N*32-1:0] instr_o;
  logic [31:0]   next_pc_o;
  logic          fill_valid_i = 1'b0;
  logic [31:0]   fill_pc_i = '0;
  logic [31:0]   fill_instr_i = '0;
  logic          fill_br_i = 1'b0;
  logic          fill_taken_i = 1'b0;
  logic [31:0]   fill_tgt_i = '0;

  always #5 clk_i = ~clk_i;

  trace_cache #(.PC_W(32), .INSTR_W(32), .TRACE_LEN(N), .MAX_BR(M), .SETS(S), .INSTR_BYTES(4))
  i_trace_cache (.*);

  int tests = 0;
  int fails = 0;

  // reference model, one entry per set
  bit          m_valid [S];
  logic [31:0] m_spc   [S];
  int          m_len   [S];
  int          m_brc   [S];
  bit          m_endbr [S];
  bit [M-2:0]  m_flags [S];
  logic [31:0] m_last  [S];
  logic [31:0] m_tgt   [S];
  logic [31:0] m_ins   [S][N];

  logic [31:0] old_pc [64];
  int          n_old = 0;
  int          tag_seed = 1;

  function automatic void check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endfunction

  function automatic bit exp_hit(logic [31:0] pc, logic [M-1:0] pr);
    int s = int'(pc[3:2]);
    int inner;
    if (!m_valid[s] || m_spc[s][31:4] != pc[31:4]) return 1'b0;
    inner = m_brc[s] - int'(m_endbr[s]);
    for (int k = 0; k < M - 1; k++)
      if (k < inner && pr[k] != m_flags[s][k]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_next(logic [31:0] pc, logic [M-1:0] pr);
    int s = int'(pc[3:2]);
    if (m_endbr[s] && pr[m_brc[s]-1]) return m_tgt[s];
    return m_last[s] + 32'd4;
  endfunction

  task automatic look(logic [31:0] pc, logic [M-1:0] pr, string req);
    bit eh;
    int s;
    @(negedge clk_i);
    lookup_i = 1'b1; fetch_pc_i = pc; pred_i = pr;
    #1;
    eh = exp_hit(pc, pr);
    s = int'(pc[3:2]);
    check(hit_o == eh, req, "hit", {31'b0, hit_o}, {31'b0, eh});
    if (eh) begin
      check(len_o == 5'(m_len[s]), "R4", "len", {27'b0, len_o}, m_len[s]);
      check(next_pc_o == exp_next(pc, pr), "R5", "next_pc", next_pc_o, exp_next(pc, pr));
      for (int k = 0; k < N; k++)
        check(instr_o[k*32 +: 32] == ((k < m_len[s]) ? m_ins[s][k] : 32'h0), "R4",
              $sformatf("slot %0d", k), instr_o[k*32 +: 32],
              (k < m_len[s]) ? m_ins[s][k] : 32'h0);
    end else begin
      check(len_o == 0 && next_pc_o == 0 && instr_o == '0, "R2", "miss outputs",
            next_pc_o | {27'b0, len_o}, 32'h0);
    end
  endtask

  task automatic drive_fill(logic v, logic [31:0] pc, logic [31:0] ins, logic br, logic tk, logic [31:0] tg);
    @(negedge clk_i);
    lookup_i = 1'b0;
    fill_valid_i = v; fill_pc_i = pc; fill_instr_i = ins;
    fill_br_i = br; fill_taken_i = tk; fill_tgt_i = tg;
  endtask

  // mode 0 random, 1 no branches, 2 all branches, 3 single branch in last slot
  task automatic run_trace(int set, int mode);
    logic [31:0] spc, pc;
    int s, len, brc;
    bit endbr, br, tk;
    bit [M-2:0] flags;
    logic [31:0] last, tgt, tg, ins;
    logic [31:0] buff [N];
    spc = {tag_seed[27:0], set[1:0], 2'b00};
    tag_seed++;
    s = set;
    // decoy miss, then the real one replaces it (R6)
    look({tag_seed[27:0] ^ 28'hABCDE, set[1:0], 2'b00}, '0, "R6");
    look(spc, '0, "R6");
    // instructions with other PCs are ignored while waiting (R6)
    drive_fill(1'b1, spc + 32'h4000_0000, 32'hDEAD_0001, 1'b1, 1'b1, 32'h0);
    drive_fill(1'b1, spc + 32'h8000_0000, 32'hDEAD_0002, 1'b0, 1'b0, 32'h0);
    pc = spc; len = 0; brc = 0; endbr = 0; flags = '0; last = '0; tgt = '0;
    for (int k = 0; k < N; k++) buff[k] = '0;
    forever begin
      case (mode)
        1:       br = 1'b0;
        2:       br = 1'b1;
        3:       br = (len == N - 1);
        default: br = ($urandom % 5 == 0);
      endcase
      tk  = $urandom % 2;
      tg  = $urandom & 32'hFFFF_FFFC;
      ins = $urandom;
      drive_fill(1'b1, pc, ins, br, tk, tg);
      if (br) begin
        if (brc < M - 1) flags[brc] = tk;
        brc++;
        tgt = tg;
      end
      endbr = br; last = pc; buff[len] = ins; len++;
      pc = (br && tk) ? tg : pc + 32'd4;
      if (len == N || brc == M) break;  // R7
    end
    // write cycle: offered instruction ignored (R8), same-set lookup misses (R9)
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_pc_i = pc; fill_instr_i = 32'hBAD0_BAD0; fill_br_i = 1'b0;
    lookup_i = 1'b1; fetch_pc_i = spc; pred_i = '0;
    #1;
    check(hit_o == 1'b0, "R9", "write-cycle lookup", {31'b0, hit_o}, 32'h0);
    @(negedge clk_i);
    fill_valid_i = 1'b0; lookup_i = 1'b0;
    m_valid[s] = 1'b1; m_spc[s] = spc; m_len[s] = len; m_brc[s] = brc;
    m_endbr[s] = endbr; m_flags[s] = flags; m_last[s] = last; m_tgt[s] = tgt;
    for (int k = 0; k < N; k++) m_ins[s][k] = buff[k];
    if (n_old < 64) begin old_pc[n_old] = spc; n_old++; end
    // R3/R5: matching predictions with terminal bit both ways
    look(spc, {1'b0, flags}, "R3");
    look(spc, {1'b1, flags} | ((M)'(1) << (brc > 0 ? brc - 1 : 0)), "R5");
    look(spc, {1'b1, flags} & ~((M)'(1) << (brc > 0 ? brc - 1 : 0)), "R5");
    // R3: flipped interior prediction
    if (brc - int'(endbr) > 0) look(spc, {1'b0, flags} ^ (M)'(1), "R3");
    // R3: foreign tag, same set
    look(spc ^ 32'h0100_0000, {1'b0, flags}, "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int s = 0; s < S; s++) m_valid[s] = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R1: nothing hits after reset
    for (int s = 0; s < S; s++) look({28'h1357, s[1:0], 2'b00}, '0, "R1");
    run_trace(0, 1);   // R7 count limit, no branches
    run_trace(1, 2);   // R7 branch limit
    run_trace(2, 3);   // R5 terminal branch closed by count limit
    run_trace(3, 0);
    for (int t = 0; t < 20; t++) begin
      run_trace(int'($urandom % S), 0);
      // R10: an older start PC in a replaced set must miss
      if (n_old > 1) look(old_pc[$urandom % (n_old - 1)], '0, "R10");
    end
    run_trace(0, 2);
    look(old_pc[0], '0, "R10");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule